// File: doc/BRIEF.md
# Cycle-Stealing Block DMA Engine

This block is a single-channel engine that moves a block of words from a device-side stream into memory without the processor touching each word. Software first loads a target memory address and a word count into two registers while the engine is idle. It then writes a start command. From then on the engine takes one word at a time from the device stream and writes it to memory through a request/grant port. Each written word advances the address by one and lowers the remaining count by one.

The engine never holds the memory bus for a burst. After every granted word it drops its request for at least one cycle, so the processor gets the bus in between. When the remaining count reaches zero, the engine goes back to idle and raises a completion interrupt. That interrupt stays set until software clears it by writing a one to its status bit. A start written while a transfer is running has no effect on the transfer and sets a sticky error flag. A start with a count of zero completes at once and never requests the bus.

The register interface is a single-cycle write strobe with a two-bit register select and a combinational read path. Select 0 is the command register, with start in bit 0. Select 1 is the address register and select 2 is the count register; both read back live values. Select 3 is status, with bit 0 ready, bit 1 busy, bit 2 interrupt and bit 3 error.

Top module: `dma_steal_engine`

## Requirements
- R1: After reset, status reads ready=1, busy=0, interrupt=0 and error=0 (value 4'b0001 in bits 3:0). The address and count registers read 0, and mem_req and irq are low.
- R2: While idle, a write to select 1 loads the address and a write to select 2 loads the count. Both values read back unchanged from the same selects.
- R3: A write to select 0 with bit 0 set, while idle and with a nonzero count, makes status read busy=1 and ready=0 from the next cycle on.
- R4: In a cycle with mem_req and mem_gnt both high, mem_addr carries the current address and mem_wdata carries dev_data, and dev_ready is high. From the next cycle the address is one higher and the count (select 2) is one lower.
- R5: In the cycle after any granted word, mem_req is low.
- R6: mem_req is high only while busy and only while dev_valid is high.
- R7: In the cycle after the grant of the last word (count was 1), status reads busy=0, ready=1 and interrupt=1, and the irq output is high.
- R8: A write to select 3 with bit 2 set clears the interrupt, and with bit 3 set clears the error. A zero in either bit leaves that flag as it was.
- R9: A start written while busy leaves the running transfer's address and count unchanged and sets the error bit (status bit 3).
- R10: A start with a count of 0 raises the interrupt in the next cycle, never sets busy and never raises mem_req.
- R11: Writes to the address and count registers while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 address, 2 count, 3 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| dev_valid | input | 1 | Device stream holds a word |
| dev_data | input | DATA_W | Device stream word |
| dev_ready | output | 1 | Word taken from the device stream this cycle |
| mem_req | output | 1 | Memory bus request for one word |
| mem_gnt | input | 1 | Memory bus grant |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
The main transfer is run in two ways. The first uses a device that always has data and a bus that always grants, which shows the minimum two-cycle spacing between words. The second stalls the device every third cycle and grants only every other cycle, which shows that requests follow dev_valid and that a word moves only when the grant arrives. In both runs, every granted word is checked against the address and data the bench expects, and the remaining count is read back on each cycle. Separate runs start a transfer while another is in progress, start one with a zero count, and clear the status flags in different combinations. These tell apart the rule that the error flag is sticky, the rule that a zero count completes at once, and the rule that a write of 1 clears a flag.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    localparam int ST_READY = 0;
    localparam int ST_BUSY  = 1;
    localparam int ST_IRQ   = 2;
    localparam int ST_ERR   = 3;
    localparam int CMD_GO   = 0;
endpackage

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              go,
    input  logic              clr_irq,
    input  logic              clr_err,
    input  logic              dev_valid,
    input  logic              mem_gnt,
    output logic              mem_req,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              busy,
    output logic              irq,
    output logic              err
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              cool;
        logic              irq;
        logic              err;
    } st_t;

    st_t st_d, st_q;
    logic req_c, take_c;

    always_comb begin
        st_d   = st_q;
        req_c  = st_q.busy && !st_q.cool && dev_valid;
        take_c = req_c && mem_gnt;
        st_d.cool = take_c;

        if (!st_q.busy) begin
            if (ld_addr) st_d.addr = addr_in;
            if (ld_cnt)  st_d.cnt  = cnt_in;
        end

        if (clr_irq) st_d.irq = 1'b0;
        if (clr_err) st_d.err = 1'b0;

        if (go) begin
            if (st_q.busy)            st_d.err  = 1'b1;
            else if (st_q.cnt == '0)  st_d.irq  = 1'b1;
            else                      st_d.busy = 1'b1;
        end

        if (take_c) begin
            st_d.addr = st_q.addr + 1'b1;
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_ONE) begin
                st_d.busy = 1'b0;
                st_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req = req_c;
    assign addr    = st_q.addr;
    assign cnt     = st_q.cnt;
    assign busy    = st_q.busy;
    assign irq     = st_q.irq;
    assign err     = st_q.err;
endmodule

// File: rtl/dma_reg_rdmux.sv
module dma_reg_rdmux
    import dma_steal_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              busy,
    input  logic              irq,
    input  logic              err,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(sel))
            SEL_CMD:  rdata = '0;
            SEL_ADDR: rdata = DATA_W'(addr);
            SEL_CNT:  rdata = DATA_W'(cnt);
            SEL_STAT: begin
                rdata[ST_READY] = !busy;
                rdata[ST_BUSY]  = busy;
                rdata[ST_IRQ]   = irq;
                rdata[ST_ERR]   = err;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine
    import dma_steal_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              irq
);
    logic              go_w, ld_addr_w, ld_cnt_w, clr_irq_w, clr_err_w;
    logic              busy_w, irq_w, err_w;
    logic [ADDR_W-1:0] addr_w;
    logic [CNT_W-1:0]  cnt_w;

    assign go_w      = reg_wr && (reg_sel_e'(reg_sel) == SEL_CMD)  && reg_wdata[CMD_GO];
    assign ld_addr_w = reg_wr && (reg_sel_e'(reg_sel) == SEL_ADDR);
    assign ld_cnt_w  = reg_wr && (reg_sel_e'(reg_sel) == SEL_CNT);
    assign clr_irq_w = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT) && reg_wdata[ST_IRQ];
    assign clr_err_w = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT) && reg_wdata[ST_ERR];

    dma_xfer_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_addr   (ld_addr_w),
        .ld_cnt    (ld_cnt_w),
        .addr_in   (reg_wdata[ADDR_W-1:0]),
        .cnt_in    (reg_wdata[CNT_W-1:0]),
        .go        (go_w),
        .clr_irq   (clr_irq_w),
        .clr_err   (clr_err_w),
        .dev_valid (dev_valid),
        .mem_gnt   (mem_gnt),
        .mem_req   (mem_req),
        .addr      (addr_w),
        .cnt       (cnt_w),
        .busy      (busy_w),
        .irq       (irq_w),
        .err       (err_w)
    );

    dma_reg_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
        .sel   (reg_sel),
        .addr  (addr_w),
        .cnt   (cnt_w),
        .busy  (busy_w),
        .irq   (irq_w),
        .err   (err_w),
        .rdata (reg_rdata)
    );

    assign dev_ready = mem_req && mem_gnt;
    assign mem_addr  = addr_w;
    assign mem_wdata = dev_data;
    assign irq       = irq_w;
endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_valid,
    input logic              go,
    input logic              busy,
    input logic              irq,
    input logic              err,
    input logic [CNT_W-1:0]  cnt
);
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_novalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_valid |-> !mem_req);

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> (mem_addr == $past(mem_addr) + 1'b1));

    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && cnt == CNT_W'(1)) |=> (irq && !busy));

    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && cnt == '0) |=> (irq && !busy));

    p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy) |=> (err && $stable(cnt)));
endmodule

bind dma_steal_engine dma_steal_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .dev_valid (dev_valid),
    .go        (go_w),
    .busy      (busy_w),
    .irq       (irq_w),
    .err       (err_w),
    .cnt       (cnt_w)
);

// File: tb/sim_dma_steal_engine.sv
module sim_dma_steal_engine;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              dev_valid = 1'b0;
    logic [DATA_W-1:0] dev_data = '0;
    logic              dev_ready;
    logic              mem_req;
    logic              mem_gnt = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_steal_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_valid(dev_valid),
        .dev_data(dev_data), .dev_ready(dev_ready), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DATA_W-1:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        rd(2'd3, v); check(v[3:0] == 4'b0001, "R1 status", v[3:0], 4'b0001);
        rd(2'd1, v); check(v == 0, "R1 addr", v, 0);
        rd(2'd2, v); check(v == 0, "R1 count", v, 0);
        check(!mem_req && !irq, "R1 req/irq", {mem_req, irq}, 0);
    endtask

    task automatic t_program();
        logic [DATA_W-1:0] v;
        wr(2'd1, 32'h0000_1234);
        wr(2'd2, 32'h0000_0ABC);
        rd(2'd1, v); check(v == 32'h1234, "R2 addr", v, 32'h1234);
        rd(2'd2, v); check(v == 32'hABC, "R2 count", v, 32'hABC);
    endtask

    task automatic run_xfer(input int base, input int n, input bit stall, input string tag);
        logic [DATA_W-1:0] v;
        int k = 0;
        int guard = 0;
        bit prev = 1'b0;
        wr(2'd3, 32'h0000_000C);
        wr(2'd1, DATA_W'(base));
        wr(2'd2, DATA_W'(n));
        wr(2'd0, 32'h1);
        rd(2'd3, v); check(v[1:0] == 2'b10, "R3 busy after start", v[1:0], 2'b10);
        while (k < n && guard < 2000) begin
            @(negedge clk);
            dev_valid = stall ? ((guard % 3) != 2) : 1'b1;
            mem_gnt   = stall ? ((guard % 2) == 0) : 1'b1;
            dev_data  = 32'hA500_0000 + DATA_W'(base + k);
            reg_sel   = 2'd2;
            #1;
            if (prev) check(!mem_req, "R5 gap after grant", mem_req, 0);
            if (!dev_valid) check(!mem_req, "R6 no req without data", mem_req, 0);
            check(reg_rdata == DATA_W'(n - k), "R4 remaining count", reg_rdata, n - k);
            prev = mem_req && mem_gnt;
            if (prev) begin
                check(mem_addr == ADDR_W'(base + k), "R4 address", mem_addr, base + k);
                check(mem_wdata == 32'hA500_0000 + DATA_W'(base + k), "R4 data", mem_wdata,
                      32'hA500_0000 + base + k);
                check(dev_ready, "R4 dev_ready", dev_ready, 1);
                k++;
            end
            guard++;
        end
        check(k == n, {"R4 words moved ", tag}, k, n);
        @(negedge clk);
        dev_valid = 1'b0; mem_gnt = 1'b0;
        rd(2'd3, v); check(v[3:0] == 4'b0101, {"R7 status at end ", tag}, v[3:0], 4'b0101);
        check(irq, "R7 irq output", irq, 1);
        check(!mem_req, "R6 idle no req", mem_req, 0);
        rd(2'd1, v); check(v == DATA_W'(ADDR_W'(base + n)), "R4 final addr", v, base + n);
    endtask

    task automatic t_clear();
        logic [DATA_W-1:0] v;
        wr(2'd3, 32'h0000_0008);
        rd(2'd3, v); check(v[2] == 1'b1, "R8 irq kept on zero bit", v[2], 1);
        wr(2'd3, 32'h0000_0004);
        rd(2'd3, v); check(v[2] == 1'b0, "R8 irq cleared", v[2], 0);
        check(!irq, "R8 irq output low", irq, 0);
    endtask

    task automatic t_busy_start();
        logic [DATA_W-1:0] v;
        dev_valid = 1'b0; mem_gnt = 1'b1;
        wr(2'd1, 32'h0000_0200);
        wr(2'd2, 32'h0000_0004);
        wr(2'd0, 32'h1);
        wr(2'd0, 32'h1);
        rd(2'd3, v); check(v[3] == 1'b1, "R9 error set", v[3], 1);
        rd(2'd2, v); check(v == 4, "R9 count unchanged", v, 4);
        wr(2'd2, 32'h0000_0009);
        wr(2'd1, 32'h0000_0777);
        rd(2'd2, v); check(v == 4, "R11 count write ignored", v, 4);
        rd(2'd1, v); check(v == 32'h200, "R11 addr write ignored", v, 32'h200);
        wr(2'd3, 32'h0000_0004);
        rd(2'd3, v); check(v[3] == 1'b1, "R8 error kept on zero bit", v[3], 1);
        wr(2'd3, 32'h0000_0008);
        rd(2'd3, v); check(v[3] == 1'b0, "R8 error cleared", v[3], 0);
        dev_valid = 1'b1;
        for (int i = 0; i < 20; i++) @(negedge clk);
        dev_valid = 1'b0; mem_gnt = 1'b0;
        rd(2'd3, v); check(v[3:0] == 4'b0101, "R7 finished after busy start", v[3:0], 4'b0101);
        rd(2'd1, v); check(v == 32'h204, "R4 addr after busy start", v, 32'h204);
    endtask

    task automatic t_zero();
        logic [DATA_W-1:0] v;
        bit saw_req = 1'b0;
        wr(2'd3, 32'h0000_000C);
        wr(2'd2, 32'h0);
        dev_valid = 1'b1; mem_gnt = 1'b1;
        wr(2'd0, 32'h1);
        rd(2'd3, v); check(v[3:0] == 4'b0101, "R10 zero count done", v[3:0], 4'b0101);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            if (mem_req) saw_req = 1'b1;
            if (reg_rdata[1]) saw_req = 1'b1;
        end
        check(!saw_req, "R10 no request or busy", saw_req, 0);
        dev_valid = 1'b0; mem_gnt = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        run_xfer(16'h0100, 5, 1'b0, "steady");
        t_clear();
        run_xfer(16'hFFFD, 7, 1'b1, "stalled");
        t_busy_start();
        t_zero();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule